// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the device-side end of a two-wire programming link. A host toggles a serial clock and a data line; the block oversamples both with the fast system clock, finds the edges of the serial clock, and assembles 6-bit commands sent least significant bit first. Each command is decoded into a single-cycle strobe toward the memory access controller.

Load and read commands are followed by a separate 16-clock data frame. The first and last clocks of that frame are dummies. For a load, the 14 bits in between are shifted in and the low 12 are handed to the memory side. For a read, the block captures the addressed word and turns the data pin around to drive it back. Begin-programming and end-programming bracket an externally timed write. A begin with no fresh load is refused and latches an error flag. Entry into programming mode is reduced to a single enable input. Dropping that input returns every piece of state to idle.

Top module: `prog_cmd_slave`

## Requirements
- R1: A command is taken from 6 consecutive serial-clock falling edges, least significant bit first. Only the low 4 bits select the command. The 2 upper bits have no effect.
- R2: Code 4'b0010 starts a load frame of 16 falling edges. Edges 2 through 15 carry a 14-bit word, least significant bit first. After edge 16 `ld_stb` pulses and `ld_word` holds the low 12 bits; the top 2 bits are discarded.
- R3: Code 4'b0100 pulses `rd_stb` at decode and starts a read frame. `rd_word` is captured at the first rising edge of the frame. From the 2nd through the 15th rising edge the block drives 14 bits, least significant bit first, with the top 2 bits as 0. Each bit is updated on a rising edge so the host can sample it on the next falling edge.
- R4: `sdat_oe` rises at the 2nd rising edge of a read frame and falls at the 16th. It is low at all other times. `sdat_out` is 0 whenever `sdat_oe` is low.
- R5: Code 4'b0110 pulses `inc_stb` and code 4'b1001 pulses `erase_stb`. Each pulse lasts one system-clock cycle.
- R6: Code 4'b1000, when a load has completed since the last programming start, pulses `prog_start` and sets `prog_active`. Code 4'b1110 while active pulses `prog_end` and clears `prog_active`.
- R7: Code 4'b1000 with no load since the last programming start produces no `prog_start`. It sets `seq_err`, which then stays set while `mode_en` remains high.
- R8: While `mode_en` is low, the bit counter, frame phase, pending-load, active and error state are cleared and the data line is released. A partly shifted command is discarded.
- R9: A command whose low 4 bits match none of the six codes produces no strobe and no state change.
- R10: At most one of the six strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | High while programming mode is entered |
| sclk_in | input | 1 | Serial clock from host |
| sdat_in | input | 1 | Serial data from host |
| sdat_out | output | 1 | Serial data driven to host during reads |
| sdat_oe | output | 1 | Output enable for the data pin |
| rd_word | input | 12 | Addressed memory word supplied for reads |
| ld_word | output | 12 | Last word received by a load frame |
| ld_stb | output | 1 | Load frame complete |
| rd_stb | output | 1 | Read command decoded |
| inc_stb | output | 1 | Increment-address command |
| prog_start | output | 1 | Programming cycle begins |
| prog_end | output | 1 | Programming cycle ends |
| erase_stb | output | 1 | Bulk-erase command |
| prog_active | output | 1 | Programming cycle in progress |
| seq_err | output | 1 | Sticky flag for a begin without a load |

## Verification
Load and read frames are sent with all-ones, all-zeros, alternating and sparse 14-bit words. Words whose upper two bits are set show that those bits are discarded. The alternating patterns expose a reversed bit order or a shift that is off by one. Each vector also sets the upper two command bits differently, which shows whether decoding looks only at the low nibble. Read frames record the enable at every rising edge, so an early or late turnaround shows up separately from a wrong data bit. Directed sequences cover a begin with no load, a repeated begin, an unused code, and leaving the mode part-way through a command or a read.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;
    typedef enum logic [2:0] {
        CMD_NONE, CMD_LOAD, CMD_READ, CMD_INC, CMD_BEGIN, CMD_END, CMD_ERASE
    } cmd_e;

    typedef enum logic [1:0] {
        PH_CMD, PH_LOAD, PH_READ
    } phase_e;

    localparam logic [3:0] CODE_LOAD  = 4'b0010;
    localparam logic [3:0] CODE_READ  = 4'b0100;
    localparam logic [3:0] CODE_INC   = 4'b0110;
    localparam logic [3:0] CODE_BEGIN = 4'b1000;
    localparam logic [3:0] CODE_END   = 4'b1110;
    localparam logic [3:0] CODE_ERASE = 4'b1001;
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdat_in,
    output logic rise,
    output logic fall,
    output logic dat
);
    // The clock chain has one extra stage so that the edge compare and the
    // sampled data come from the same synchronizer depth.
    logic [STAGES:0]   ck_d, ck_q;
    logic [STAGES-1:0] dt_d, dt_q;

    always_comb begin
        ck_d = {ck_q[STAGES-1:0], sclk_in};
        dt_d = {dt_q[STAGES-2:0], sdat_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q <= '0;
            dt_q <= '0;
        end else begin
            ck_q <= ck_d;
            dt_q <= dt_d;
        end
    end

    assign rise = ck_q[STAGES-1] & ~ck_q[STAGES];
    assign fall = ~ck_q[STAGES-1] & ck_q[STAGES];
    assign dat  = dt_q[STAGES-1];
endmodule

// File: rtl/ser_cmd_decode.sv
module ser_cmd_decode
    import prog_cmd_pkg::*;
(
    input  logic [3:0] code,
    output cmd_e       cmd
);
    always_comb begin
        case (code)
            CODE_LOAD:  cmd = CMD_LOAD;
            CODE_READ:  cmd = CMD_READ;
            CODE_INC:   cmd = CMD_INC;
            CODE_BEGIN: cmd = CMD_BEGIN;
            CODE_END:   cmd = CMD_END;
            CODE_ERASE: cmd = CMD_ERASE;
            default:    cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/prog_cmd_slave.sv
module prog_cmd_slave
    import prog_cmd_pkg::*;
#(
    parameter int CMD_BITS  = 6,
    parameter int DATA_BITS = 14,
    parameter int WORD_BITS = 12,
    parameter int SYNC_STG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_en,
    input  logic                 sclk_in,
    input  logic                 sdat_in,
    output logic                 sdat_out,
    output logic                 sdat_oe,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic [WORD_BITS-1:0] ld_word,
    output logic                 ld_stb,
    output logic                 rd_stb,
    output logic                 inc_stb,
    output logic                 prog_start,
    output logic                 prog_end,
    output logic                 erase_stb,
    output logic                 prog_active,
    output logic                 seq_err
);
    localparam int FRAME = DATA_BITS + 2;
    localparam int CNT_W = $clog2(FRAME);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_BITS);
    localparam int CODE_LSB = DATA_BITS - CMD_BITS;

    typedef struct packed {
        phase_e                phase;
        logic [CNT_W-1:0]      cnt;
        logic [DATA_BITS-1:0]  sh;
        logic                  oe;
        logic                  dout;
        logic [WORD_BITS-1:0]  word;
        logic                  ld_pend;
        logic                  active;
        logic                  err;
        logic                  p_ld, p_rd, p_inc, p_beg, p_end, p_era;
    } st_t;

    st_t d, q;

    logic rise_w, fall_w, dat_w;
    logic [DATA_BITS-1:0] sh_in;
    cmd_e cmd_w;

    ser_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
        .rise(rise_w), .fall(fall_w), .dat(dat_w)
    );

    assign sh_in = {dat_w, q.sh[DATA_BITS-1:1]};

    ser_cmd_decode u_dec (
        .code(sh_in[CODE_LSB +: 4]),
        .cmd (cmd_w)
    );

    always_comb begin
        d       = q;
        d.p_ld  = 1'b0;
        d.p_rd  = 1'b0;
        d.p_inc = 1'b0;
        d.p_beg = 1'b0;
        d.p_end = 1'b0;
        d.p_era = 1'b0;
        if (!mode_en) begin
            d = '0;
            d.word = q.word;
        end else begin
            case (q.phase)
                PH_CMD: begin
                    if (fall_w) begin
                        d.sh = sh_in;
                        if (q.cnt == CMD_LAST) begin
                            d.cnt = '0;
                            case (cmd_w)
                                CMD_LOAD: d.phase = PH_LOAD;
                                CMD_READ: begin
                                    d.phase = PH_READ;
                                    d.p_rd  = 1'b1;
                                end
                                CMD_INC:   d.p_inc = 1'b1;
                                CMD_ERASE: d.p_era = 1'b1;
                                CMD_BEGIN: begin
                                    if (q.ld_pend) begin
                                        d.p_beg   = 1'b1;
                                        d.active  = 1'b1;
                                        d.ld_pend = 1'b0;
                                    end else begin
                                        d.err = 1'b1;
                                    end
                                end
                                CMD_END: begin
                                    if (q.active) begin
                                        d.p_end  = 1'b1;
                                        d.active = 1'b0;
                                    end
                                end
                                default: ;
                            endcase
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_LOAD: begin
                    if (fall_w) begin
                        if (q.cnt >= CNT_W'(1) && q.cnt <= DATA_LAST)
                            d.sh = sh_in;
                        if (q.cnt == FRAME_LAST) begin
                            d.cnt     = '0;
                            d.phase   = PH_CMD;
                            d.word    = q.sh[WORD_BITS-1:0];
                            d.p_ld    = 1'b1;
                            d.ld_pend = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_READ: begin
                    if (rise_w) begin
                        if (q.cnt == '0) begin
                            d.sh = {{(DATA_BITS-WORD_BITS){1'b0}}, rd_word};
                        end else if (q.cnt <= DATA_LAST) begin
                            d.oe   = 1'b1;
                            d.dout = q.sh[0];
                            d.sh   = {1'b0, q.sh[DATA_BITS-1:1]};
                        end else begin
                            d.oe   = 1'b0;
                            d.dout = 1'b0;
                        end
                    end else if (fall_w) begin
                        if (q.cnt == FRAME_LAST) begin
                            d.cnt   = '0;
                            d.phase = PH_CMD;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.phase = PH_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdat_out    = q.dout;
    assign sdat_oe     = q.oe;
    assign ld_word     = q.word;
    assign ld_stb      = q.p_ld;
    assign rd_stb      = q.p_rd;
    assign inc_stb     = q.p_inc;
    assign prog_start  = q.p_beg;
    assign prog_end    = q.p_end;
    assign erase_stb   = q.p_era;
    assign prog_active = q.active;
    assign seq_err     = q.err;
endmodule

// File: rtl/prog_cmd_slave_chk.sv
module prog_cmd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_en,
    input logic sdat_out,
    input logic sdat_oe,
    input logic ld_stb,
    input logic rd_stb,
    input logic inc_stb,
    input logic prog_start,
    input logic prog_end,
    input logic erase_stb,
    input logic prog_active,
    input logic seq_err
);
    logic seen_ld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      seen_ld_q <= 1'b0;
        else if (!mode_en || prog_start) seen_ld_q <= 1'b0;
        else if (ld_stb)                 seen_ld_q <= 1'b1;
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_stb, rd_stb, inc_stb, prog_start, prog_end, erase_stb}));

    a_r8_release_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !sdat_oe && !prog_active && !seq_err);

    a_r4_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !sdat_oe |-> !sdat_out);

    a_r6_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> prog_active);

    a_r6_end_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
        prog_end |-> !prog_active);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && mode_en) |=> seq_err);

    a_r7_start_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_start) |-> $past(seen_ld_q));
endmodule

bind prog_cmd_slave prog_cmd_slave_chk u_chk (.*);

// File: tb/tb_prog_cmd_slave.sv
`timescale 1ns/1ps
module tb_prog_cmd_slave;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_en = 1'b0;
    logic        sclk_in = 1'b0;
    logic        sdat_in = 1'b0;
    logic [11:0] rd_word = '0;
    logic        sdat_out, sdat_oe;
    logic [11:0] ld_word;
    logic        ld_stb, rd_stb, inc_stb, prog_start, prog_end, erase_stb;
    logic        prog_active, seq_err;

    int total = 0;
    int fails = 0;
    int n_ld = 0, n_rd = 0, n_inc = 0, n_beg = 0, n_end = 0, n_era = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prog_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .sclk_in(sclk_in), .sdat_in(sdat_in),
        .sdat_out(sdat_out), .sdat_oe(sdat_oe),
        .rd_word(rd_word), .ld_word(ld_word),
        .ld_stb(ld_stb), .rd_stb(rd_stb), .inc_stb(inc_stb),
        .prog_start(prog_start), .prog_end(prog_end), .erase_stb(erase_stb),
        .prog_active(prog_active), .seq_err(seq_err)
    );

    always @(negedge clk) begin
        if (ld_stb)     n_ld++;
        if (rd_stb)     n_rd++;
        if (inc_stb)    n_inc++;
        if (prog_start) n_beg++;
        if (prog_end)   n_end++;
        if (erase_stb)  n_era++;
    end

    // {upper command bits, 14-bit data word}
    localparam logic [15:0] VEC [6] = '{
        {2'b00, 14'h3FFF}, {2'b11, 14'h0000}, {2'b01, 14'h2AAA},
        {2'b10, 14'h1555}, {2'b11, 14'h3001}, {2'b00, 14'h0C35}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sclk_in = 1'b1; sdat_in = b;
        wait_clk(H);
        sclk_in = 1'b0;
        wait_clk(H);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) send_bit(c[i]);
        wait_clk(H);
    endtask

    task automatic send_load(input logic [13:0] w);
        send_bit(1'b1);
        for (int i = 0; i < 14; i++) send_bit(w[i]);
        send_bit(1'b1);
        wait_clk(H);
    endtask

    task automatic recv_read(output logic [13:0] w, output logic [15:0] oe_pat);
        w = '0; oe_pat = '0;
        for (int k = 0; k < 16; k++) begin
            sclk_in = 1'b1; sdat_in = 1'b0;
            wait_clk(H);
            oe_pat[k] = sdat_oe;
            if (k >= 1 && k <= 14) w[k-1] = sdat_out;
            sclk_in = 1'b0;
            wait_clk(H);
        end
        wait_clk(H);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [13:0] rw;
        logic [15:0] op;
        int b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R8 reset outputs",
            {28'd0, sdat_oe, sdat_out, prog_active, seq_err}, 32'd0);
        mode_en = 1'b1;
        wait_clk(4);

        // R7: begin with no load since entry
        send_cmd(6'b001000);
        chk("R7 begin without load sets error", {31'd0, seq_err}, 32'd1);
        chk("R7 begin without load no start", n_beg, 0);

        // Table walk: loads and reads, upper command bits varied (R1)
        foreach (VEC[i]) begin
            int ld0, rd0;
            ld0 = n_ld; rd0 = n_rd;
            send_cmd({VEC[i][15:14], 4'b0010});
            send_load(VEC[i][13:0]);
            chk("R1 load decoded despite upper bits", n_ld, ld0 + 1);
            chk("R2 load word low 12 bits", {20'd0, ld_word}, {20'd0, VEC[i][11:0]});
            rd_word = ~VEC[i][11:0];
            send_cmd({VEC[i][15:14], 4'b0100});
            chk("R3 read strobe", n_rd, rd0 + 1);
            recv_read(rw, op);
            chk("R3 read word lsb first top zero", {18'd0, rw}, {18'd0, 2'b00, ~VEC[i][11:0]});
            chk("R4 turnaround edges", {16'd0, op}, 32'h0000_7FFE);
        end
        chk("R4 released after read", {31'd0, sdat_oe}, 32'd0);

        // R6: begin after load, then end
        b0 = n_beg;
        send_cmd(6'b101000);
        chk("R6 start strobe after load", n_beg, b0 + 1);
        chk("R6 active set", {31'd0, prog_active}, 32'd1);
        send_cmd(6'b001110);
        chk("R6 end strobe", n_end, 1);
        chk("R6 active cleared", {31'd0, prog_active}, 32'd0);

        // R7: second begin without a new load
        send_cmd(6'b001000);
        chk("R7 repeated begin ignored", n_beg, b0 + 1);
        chk("R7 error still set", {31'd0, seq_err}, 32'd1);

        // R5: increment and erase
        send_cmd(6'b000110);
        chk("R5 increment strobe", n_inc, 1);
        send_cmd(6'b111001);
        chk("R5 erase strobe", n_era, 1);

        // R9: unused code
        send_cmd(6'b001111);
        chk("R9 unused code no strobe",
            n_ld + n_rd + n_inc + n_beg + n_end + n_era, 6 + 6 + 1 + 1 + 1 + 1);
        chk("R9 unused code state", {30'd0, prog_active, seq_err}, 32'd1);

        // R8: leave mode part-way through a command
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        mode_en = 1'b0;
        wait_clk(4);
        chk("R8 exit clears error", {31'd0, seq_err}, 32'd0);
        mode_en = 1'b1;
        wait_clk(4);
        send_cmd(6'b000110);
        chk("R8 partial command discarded", n_inc, 2);

        // R8: leave mode during a read while driving
        send_cmd(6'b000100);
        for (int k = 0; k < 3; k++) send_bit(1'b0);
        sclk_in = 1'b1;
        wait_clk(H);
        chk("R4 driving mid read", {31'd0, sdat_oe}, 32'd1);
        mode_en = 1'b0;
        wait_clk(3);
        chk("R8 exit releases line", {30'd0, sdat_oe, sdat_out}, 32'd0);
        sclk_in = 1'b0;
        wait_clk(3);
        mode_en = 1'b1;
        wait_clk(4);
        send_cmd(6'b001001);
        chk("R8 command phase after exit", n_era, 2);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule